// File: doc/BRIEF.md
# Per-Warp Pending-Write Scoreboard

This block records which registers each warp is still waiting to have written. Each warp has a small, fixed set of slots. Each slot holds the destination register of one issued instruction whose result has not yet come back. No per-register bit array is kept. When a decoded instruction is placed into the instruction buffer, the block compares its source and destination registers against the occupied slots of its warp. It returns a dependency mask with one bit per slot, and the buffer stores that mask beside the instruction.

When an instruction with a destination issues, the block takes the lowest-numbered free slot of that warp and stores the register there. Issue of other instructions is not held up. When a result is written back, the block finds the slot holding that register and releases it. In the same cycle it broadcasts the warp and slot number, so the instruction buffer can clear that bit position in every mask it holds for the warp. An instruction is ready to issue once its stored mask is all zeros. A per-warp full flag tells the issue logic that the warp has no free slot, so an instruction with a destination must wait. Register-file data paths are not part of this block.

Top module: `pending_reg_scoreboard`

## Requirements
- R1: After a synchronous active-low reset, every slot of every warp is free, every full flag is low, and any lookup returns an all-zero mask.
- R2: While lookup is requested, bit i of `lk_dep` is 1 exactly when slot i of warp `lk_warp` is occupied and its register equals an enabled source register or the enabled destination register. While no lookup is requested, `lk_dep` is all zeros.
- R3: An allocation request to a warp that is not full is granted in the same cycle. `al_entry` names the lowest-numbered free slot, and that slot holds `al_reg` from the next cycle on.
- R4: `warp_full[w]` is high exactly when all slots of warp w are occupied. An allocation request to a full warp is refused (`al_grant` low) and changes no slot, even when a writeback frees a slot of that warp in the same cycle.
- R5: A writeback whose register matches an occupied slot of warp `wb_warp` raises `clr_valid` in the same cycle, with `clr_warp` and `clr_entry` naming that slot. The slot is free from the next cycle on. A writeback that matches no occupied slot leaves `clr_valid` low and changes nothing.
- R6: When a writeback frees slot i of a warp in the same cycle as a lookup for that warp, bit i of `lk_dep` is 0.
- R7: When an allocation is granted to slot i of a warp in the same cycle as a lookup for that warp, bit i of `lk_dep` is 1 if the allocated register equals an enabled source or destination register of the lookup.
- R8: Slots, full flags and lookups of one warp are unaffected by allocations and writebacks addressed to another warp.
- R9: A slot released by writeback is again available, and it is chosen by a later allocation whenever it is the lowest-numbered free slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request for an instruction entering the buffer |
| lk_warp | input | WARP_W | Warp of the looked-up instruction |
| lk_src | input | NUM_SRC*REG_W | Source register numbers, source k in bits [k*REG_W +: REG_W] |
| lk_src_en | input | NUM_SRC | Per-source enable |
| lk_dst_en | input | 1 | Instruction has a destination register |
| lk_dst | input | REG_W | Destination register number |
| lk_dep | output | ENTRIES | Dependency mask, bit i = depends on slot i |
| al_valid | input | 1 | Allocation request at issue |
| al_warp | input | WARP_W | Warp of the issuing instruction |
| al_reg | input | REG_W | Destination register to record |
| al_grant | output | 1 | Allocation accepted |
| al_entry | output | IDX_W | Slot chosen for the allocation |
| wb_valid | input | 1 | Writeback request |
| wb_warp | input | WARP_W | Warp of the writeback |
| wb_reg | input | REG_W | Register being written back |
| clr_valid | output | 1 | A slot is released this cycle |
| clr_warp | output | WARP_W | Warp of the released slot |
| clr_entry | output | IDX_W | Index of the released slot |
| warp_full | output | NUM_WARPS | Per-warp flag: all slots occupied |

## Verification
The bench builds the block with four warps, four slots per warp, 4-bit register numbers and two sources. These values are small enough to sweep every pair of source registers, and every destination register, against a fully occupied warp. A bench-side model of the slots predicts every mask, grant, slot choice and release broadcast. A long pseudo-random run then mixes lookups, allocations and writebacks across all warps. It reaches the same-cycle collisions (release during lookup, allocation during lookup, allocation to a full warp during a release) and slot reuse in many orders.

// File: rtl/sb_pkg.sv
// Package: shared types for the pending-write scoreboard.
// Assumes: nothing beyond standard SystemVerilog.
package sb_pkg;

    // Classification of one slot during a dependency lookup.
    typedef enum logic [1:0] {
        SB_HIT_NONE    = 2'd0,
        SB_HIT_PENDING = 2'd1,
        SB_HIT_FORWARD = 2'd2,
        SB_HIT_KILLED  = 2'd3
    } sb_hit_e;

    // Smallest slot count the scoreboard supports (index width >= 1).
    localparam int SB_MIN_ENTRIES = 2;

endpackage

// File: rtl/sb_first_free.sv
// Module: sb_first_free
// Picks the lowest-numbered clear bit of an occupancy vector.
// Assumes: N >= 2. When no bit is clear, idx is 0 and any_free is low.
module sb_first_free #(
    parameter int N = 4,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     used,
    output logic [IDX_W-1:0] idx,
    output logic             any_free
);

    // Scan from the top so the lowest clear bit is written last.
    always_comb begin
        idx      = '0;
        any_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!used[i]) begin
                idx      = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sb_warp_table.sv
// Module: sb_warp_table
// Slot storage for one warp: occupancy bits and recorded destination
// registers, with lowest-free allocation and release by register match.
// Assumes: the issue logic never records a register that is already
// pending in this warp, so at most one slot matches a writeback.
module sb_warp_table #(
    parameter int ENTRIES = 4,
    parameter int REG_W   = 6,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alloc_en,
    input  logic [REG_W-1:0]         alloc_reg,
    input  logic                     free_en,
    input  logic [REG_W-1:0]         free_reg,
    output logic [ENTRIES-1:0]       valid,
    output logic [ENTRIES*REG_W-1:0] regs,
    output logic                     full,
    output logic [IDX_W-1:0]         alloc_idx,
    output logic                     free_hit,
    output logic [IDX_W-1:0]         free_idx
);

    logic               any_free;
    logic [ENTRIES-1:0] free_match;
    logic               alloc_ok;

    sb_first_free #(.N(ENTRIES)) u_pick (
        .used     (valid),
        .idx      (alloc_idx),
        .any_free (any_free)
    );

    assign full     = !any_free;
    assign alloc_ok = alloc_en && any_free;

    // Compare the written-back register with every occupied slot.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            free_match[i] = valid[i] && (regs[i*REG_W +: REG_W] == free_reg);
        end
    end

    // Encode the matching slot (lowest wins if the caller broke the rule).
    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free_match[i]) begin
                free_idx = IDX_W'(i);
            end
        end
        free_hit = free_en && (|free_match);
    end

    // Update occupancy and recorded registers on allocate and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            regs  <= '0;
        end else begin
            if (free_hit) begin
                valid[free_idx] <= 1'b0;
            end
            if (alloc_ok) begin
                valid[alloc_idx]                 <= 1'b1;
                regs[alloc_idx*REG_W +: REG_W]   <= alloc_reg;
            end
        end
    end

    // Mask of slots below the chosen one, for the lowest-free check.
    logic [ENTRIES-1:0] below_mask;
    assign below_mask = ({{(ENTRIES-1){1'b0}}, 1'b1} << alloc_idx) - 1'b1;

    AST_ALLOC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ok |-> (!valid[alloc_idx] && ((valid & below_mask) == below_mask))); // R3

    AST_ALLOC_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_ok |=> (valid[$past(alloc_idx)] &&
                      regs[$past(alloc_idx)*REG_W +: REG_W] == $past(alloc_reg))); // R3

    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && full && !free_hit) |=> $stable(valid)); // R4

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        free_hit |=> !valid[$past(free_idx)]); // R5

    AST_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!free_hit && !alloc_en) |=> $stable(valid)); // R5

endmodule

// File: rtl/sb_dep_match.sv
// Module: sb_dep_match
// Builds the dependency mask of one instruction against one warp's
// slots, hiding a slot released this cycle and exposing a slot
// allocated this cycle.
// Assumes: fwd_idx names a slot that is free in the current state.
module sb_dep_match #(
    parameter int ENTRIES = 4,
    parameter int REG_W   = 6,
    parameter int NUM_SRC = 3,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]       valid,
    input  logic [ENTRIES*REG_W-1:0] regs,
    input  logic [NUM_SRC*REG_W-1:0] src,
    input  logic [NUM_SRC-1:0]       src_en,
    input  logic                     dst_en,
    input  logic [REG_W-1:0]         dst,
    input  logic                     kill_en,
    input  logic [IDX_W-1:0]         kill_idx,
    input  logic                     fwd_en,
    input  logic [IDX_W-1:0]         fwd_idx,
    input  logic [REG_W-1:0]         fwd_reg,
    output logic [ENTRIES-1:0]       dep
);
    import sb_pkg::*;

    sb_hit_e            cls [ENTRIES];
    logic               fwd_reg_used;

    // Does the register being allocated appear among the operands.
    always_comb begin
        fwd_reg_used = dst_en && (dst == fwd_reg);
        for (int k = 0; k < NUM_SRC; k++) begin
            if (src_en[k] && (src[k*REG_W +: REG_W] == fwd_reg)) begin
                fwd_reg_used = 1'b1;
            end
        end
    end

    // Classify each slot and derive its dependency bit.
    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
            logic [REG_W-1:0] slot_reg;
            logic             op_match;
            assign slot_reg = regs[i*REG_W +: REG_W];

            // Compare the slot register with every enabled operand.
            always_comb begin
                op_match = dst_en && (dst == slot_reg);
                for (int k = 0; k < NUM_SRC; k++) begin
                    if (src_en[k] && (src[k*REG_W +: REG_W] == slot_reg)) begin
                        op_match = 1'b1;
                    end
                end
            end

            // Priority: same-cycle release, then same-cycle allocation, then state.
            always_comb begin
                if (kill_en && (kill_idx == IDX_W'(i))) begin
                    cls[i] = SB_HIT_KILLED;
                end else if (fwd_en && (fwd_idx == IDX_W'(i)) && fwd_reg_used) begin
                    cls[i] = SB_HIT_FORWARD;
                end else if (valid[i] && op_match) begin
                    cls[i] = SB_HIT_PENDING;
                end else begin
                    cls[i] = SB_HIT_NONE;
                end
            end

            assign dep[i] = (cls[i] == SB_HIT_PENDING) || (cls[i] == SB_HIT_FORWARD);
        end
    endgenerate

endmodule

// File: rtl/pending_reg_scoreboard.sv
// Module: pending_reg_scoreboard
// Top of the per-warp pending-write scoreboard: one slot table per warp,
// a lookup port producing a per-slot dependency mask, an allocate port
// used at issue, a writeback port that releases a slot and broadcasts it,
// and per-warp full flags.
// Assumes: a register is never allocated twice in a warp while pending;
// the issue logic honours warp_full for instructions with a destination.
module pending_reg_scoreboard #(
    parameter int NUM_WARPS = 4,
    parameter int ENTRIES   = 4,
    parameter int REG_W     = 6,
    parameter int NUM_SRC   = 3,
    localparam int WARP_W   = $clog2(NUM_WARPS),
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic [WARP_W-1:0]        lk_warp,
    input  logic [NUM_SRC*REG_W-1:0] lk_src,
    input  logic [NUM_SRC-1:0]       lk_src_en,
    input  logic                     lk_dst_en,
    input  logic [REG_W-1:0]         lk_dst,
    output logic [ENTRIES-1:0]       lk_dep,
    input  logic                     al_valid,
    input  logic [WARP_W-1:0]        al_warp,
    input  logic [REG_W-1:0]         al_reg,
    output logic                     al_grant,
    output logic [IDX_W-1:0]         al_entry,
    input  logic                     wb_valid,
    input  logic [WARP_W-1:0]        wb_warp,
    input  logic [REG_W-1:0]         wb_reg,
    output logic                     clr_valid,
    output logic [WARP_W-1:0]        clr_warp,
    output logic [IDX_W-1:0]         clr_entry,
    output logic [NUM_WARPS-1:0]     warp_full
);

    logic [ENTRIES-1:0]       valid_w [NUM_WARPS];
    logic [ENTRIES*REG_W-1:0] regs_w  [NUM_WARPS];
    logic [IDX_W-1:0]         aidx_w  [NUM_WARPS];
    logic [IDX_W-1:0]         fidx_w  [NUM_WARPS];
    logic [NUM_WARPS-1:0]     fhit_w;
    logic [ENTRIES-1:0]       dep_raw;

    // One slot table per warp, addressed by decoded warp number.
    generate
        for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
            sb_warp_table #(.ENTRIES(ENTRIES), .REG_W(REG_W)) u_table (
                .clk       (clk),
                .rst_n     (rst_n),
                .alloc_en  (al_valid && (al_warp == WARP_W'(w))),
                .alloc_reg (al_reg),
                .free_en   (wb_valid && (wb_warp == WARP_W'(w))),
                .free_reg  (wb_reg),
                .valid     (valid_w[w]),
                .regs      (regs_w[w]),
                .full      (warp_full[w]),
                .alloc_idx (aidx_w[w]),
                .free_hit  (fhit_w[w]),
                .free_idx  (fidx_w[w])
            );
        end
    endgenerate

    // Allocate port result for the addressed warp.
    always_comb begin
        al_grant = al_valid && !warp_full[al_warp];
        al_entry = aidx_w[al_warp];
    end

    // Release broadcast for the addressed warp.
    always_comb begin
        clr_valid = wb_valid && fhit_w[wb_warp];
        clr_warp  = wb_warp;
        clr_entry = fidx_w[wb_warp];
    end

    sb_dep_match #(.ENTRIES(ENTRIES), .REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_match (
        .valid    (valid_w[lk_warp]),
        .regs     (regs_w[lk_warp]),
        .src      (lk_src),
        .src_en   (lk_src_en),
        .dst_en   (lk_dst_en),
        .dst      (lk_dst),
        .kill_en  (clr_valid && (wb_warp == lk_warp)),
        .kill_idx (clr_entry),
        .fwd_en   (al_grant && (al_warp == lk_warp)),
        .fwd_idx  (al_entry),
        .fwd_reg  (al_reg),
        .dep      (dep_raw)
    );

    // Mask is only meaningful while a lookup is requested.
    assign lk_dep = lk_valid ? dep_raw : '0;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (lk_dep == '0)); // R2

    AST_RELEASE_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && clr_valid && (clr_warp == lk_warp)) |-> !lk_dep[clr_entry]); // R6

    AST_ALLOC_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && al_grant && (al_warp == lk_warp) && lk_dst_en && (lk_dst == al_reg))
        |-> lk_dep[al_entry]); // R7

    AST_FULL_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        warp_full[al_warp] |-> !al_grant); // R4

    AST_OTHER_WARP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!al_valid && !wb_valid) |=> $stable(warp_full)); // R8

endmodule

// File: tb/pending_reg_scoreboard_bench.sv
module pending_reg_scoreboard_bench;

    localparam int NW = 4;
    localparam int NE = 4;
    localparam int RW = 4;
    localparam int NS = 2;
    localparam int NR = 1 << RW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid = 1'b0;
    logic [1:0]        lk_warp = '0;
    logic [NS*RW-1:0]  lk_src = '0;
    logic [NS-1:0]     lk_src_en = '0;
    logic              lk_dst_en = 1'b0;
    logic [RW-1:0]     lk_dst = '0;
    logic [NE-1:0]     lk_dep;
    logic              al_valid = 1'b0;
    logic [1:0]        al_warp = '0;
    logic [RW-1:0]     al_reg = '0;
    logic              al_grant;
    logic [1:0]        al_entry;
    logic              wb_valid = 1'b0;
    logic [1:0]        wb_warp = '0;
    logic [RW-1:0]     wb_reg = '0;
    logic              clr_valid;
    logic [1:0]        clr_warp;
    logic [1:0]        clr_entry;
    logic [NW-1:0]     warp_full;

    pending_reg_scoreboard #(.NUM_WARPS(NW), .ENTRIES(NE), .REG_W(RW), .NUM_SRC(NS))
    u_pending_reg_scoreboard (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_warp(lk_warp), .lk_src(lk_src), .lk_src_en(lk_src_en),
        .lk_dst_en(lk_dst_en), .lk_dst(lk_dst), .lk_dep(lk_dep),
        .al_valid(al_valid), .al_warp(al_warp), .al_reg(al_reg),
        .al_grant(al_grant), .al_entry(al_entry),
        .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
        .clr_valid(clr_valid), .clr_warp(clr_warp), .clr_entry(clr_entry),
        .warp_full(warp_full)
    );

    always #10 clk = ~clk;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 0;

    bit       mv [NW][NE];
    int       mr [NW][NE];

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit mfull(input int w);
        for (int e = 0; e < NE; e++) if (!mv[w][e]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int mlow(input int w);
        for (int e = 0; e < NE; e++) if (!mv[w][e]) return e;
        return 0;
    endfunction

    // One cycle: drive after a falling edge, check before the rising edge,
    // then advance the bench model.
    task automatic step(input bit lkv, input int lkw, input int s0, input bit s0e,
                        input int s1, input bit s1e, input bit de, input int d,
                        input bit alv, input int alw, input int alr,
                        input bit wbv, input int wbw, input int wbr, input string otag);
        bit  grant;
        int  aidx;
        bit  found;
        int  fidx;
        int  edep;
        int  efull;
        string dtag;
        lk_valid = lkv; lk_warp = 2'(lkw);
        lk_src = {RW'(s1), RW'(s0)}; lk_src_en = {s1e, s0e};
        lk_dst_en = de; lk_dst = RW'(d);
        al_valid = alv; al_warp = 2'(alw); al_reg = RW'(alr);
        wb_valid = wbv; wb_warp = 2'(wbw); wb_reg = RW'(wbr);

        grant = alv && !mfull(alw);
        aidx  = mlow(alw);
        found = 1'b0; fidx = 0;
        if (wbv) begin
            for (int e = NE - 1; e >= 0; e--) begin
                if (mv[wbw][e] && mr[wbw][e] == wbr) begin
                    found = 1'b1; fidx = e;
                end
            end
        end
        edep = 0;
        if (lkv) begin
            for (int e = 0; e < NE; e++) begin
                bit h;
                h = mv[lkw][e] && ((s0e && s0 == mr[lkw][e]) || (s1e && s1 == mr[lkw][e]) ||
                                   (de && d == mr[lkw][e]));
                if (found && wbw == lkw && fidx == e) h = 1'b0;
                if (grant && alw == lkw && aidx == e &&
                    ((s0e && s0 == alr) || (s1e && s1 == alr) || (de && d == alr))) h = 1'b1;
                if (h) edep |= (1 << e);
            end
        end
        efull = 0;
        for (int w = 0; w < NW; w++) if (mfull(w)) efull |= (1 << w);

        if (otag != "") dtag = otag;
        else if (found && wbw == lkw && lkv) dtag = "R6";
        else if (grant && alw == lkw && lkv) dtag = "R7";
        else dtag = "R2";

        #5;
        chk("R4 warp_full", int'(warp_full), efull);
        chk(dtag == "R2" ? "R2 lk_dep" : {dtag, " lk_dep"}, int'(lk_dep), edep);
        chk((alv && mfull(alw)) ? "R4 al_grant" : "R3 al_grant", int'(al_grant), int'(grant));
        if (grant) chk(otag != "" ? {otag, " al_entry"} : "R3 al_entry", int'(al_entry), aidx);
        chk("R5 clr_valid", int'(clr_valid), int'(found));
        if (found) begin
            chk("R5 clr_entry", int'(clr_entry), fidx);
            chk("R5 clr_warp", int'(clr_warp), wbw);
        end

        @(posedge clk);
        #1;
        if (found) mv[wbw][fidx] = 1'b0;
        if (grant) begin
            mv[alw][aidx] = 1'b1;
            mr[alw][aidx] = alr;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        bit [15:0] lfsr;
        for (int w = 0; w < NW; w++) for (int e = 0; e < NE; e++) begin
            mv[w][e] = 1'b0; mr[w][e] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, every register on every warp looks free.
        chk("R1 warp_full", int'(warp_full), 0);
        for (int w = 0; w < NW; w++)
            for (int r = 0; r < NR; r++)
                step(1, w, r, 1, r, 1, 1, r, 0, 0, 0, 0, 0, 0, "R1");

        // R3/R4: fill warp 0 with registers 3,5,7,9 in slots 0..3.
        for (int e = 0; e < NE; e++)
            step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 3 + 2 * e, 0, 0, 0, "");
        chk("R4 full after fill", int'(warp_full[0]), 1);

        // R4: allocation to the full warp is refused and leaves slots unchanged.
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 12, 0, 0, 0, "");
        step(1, 0, 12, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");

        // R2: sweep every source pair and every destination against the full warp.
        for (int a = 0; a < NR; a++)
            for (int b = 0; b < NR; b++)
                step(1, 0, a, 1, b, (a + b) % 3 != 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
        for (int d = 0; d < NR; d++)
            step(1, 0, 0, 0, 0, 0, 1, d, 0, 0, 0, 0, 0, 0, "");

        // R8: the other warps see none of warp 0's pending registers.
        for (int w = 1; w < NW; w++)
            for (int e = 0; e < NE; e++)
                step(1, w, 3 + 2 * e, 1, 0, 0, 1, 3 + 2 * e, 0, 0, 0, 0, 0, 0, "R8");

        // R4: full warp with a same-cycle release still refuses allocation.
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 13, 1, 0, 9, "");
        // R6: release of register 5 (slot 1) during a lookup of 5.
        step(1, 0, 5, 1, 7, 1, 0, 0, 0, 0, 0, 1, 0, 5, "");
        step(1, 0, 5, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5");
        // R5: writeback that matches nothing.
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 14, "");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 3, "");
        // R9: freed slot 1 is reused; R7: lookup of the same register that cycle.
        step(1, 0, 11, 1, 0, 0, 0, 0, 1, 0, 11, 0, 0, 0, "R9");
        step(1, 0, 0, 0, 0, 0, 1, 11, 1, 0, 2, 0, 0, 0, "R7");

        // Mixed pseudo-random traffic over all warps.
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            int alw, alr, wbw, wbr, lkw;
            bit alv, wbv;
            for (int k = 0; k < 16; k++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            alw = lfsr[1:0]; alr = lfsr[5:2]; alv = lfsr[6];
            for (int e = 0; e < NE; e++) if (mv[alw][e] && mr[alw][e] == alr) alv = 1'b0;
            wbw = lfsr[8:7]; wbv = lfsr[9];
            wbr = lfsr[10] ? mr[wbw][lfsr[12:11]] : int'(lfsr[14:11]);
            lkw = lfsr[15] ? alw : wbw;
            step(1, lkw, int'(lfsr[3:0]), lfsr[4], int'(lfsr[13:10]), lfsr[11],
                 lfsr[0], lfsr[5] ? alr : wbr, alv, alw, alr, wbv, wbw, wbr, "");
        end
        idle();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule